// File: doc/BRIEF.md
# Two-Port RAM with FIFO Mode and Parity

This block is a 256-word by 9-bit storage array with one write port and one read port. Both ports can be used in the same clock cycle. A configuration input picks one of two uses. In addressed mode, the caller supplies the write and read addresses. In queue mode, internal write and read pointers supply the addresses, and the block reports full, empty and a fill level. The block never overwrites unread data and never moves past the newest word.

Each port has a timing choice. The write port can take its inputs straight into the array at the next clock edge, or hold them in an input register for one extra cycle. The read port can present the array word combinationally, or through an output register that loads on the clock edge after the read. The ninth bit can serve as parity. When parity generation is on, the block computes the stored ninth bit itself from the eight data bits. When parity checking is on, the block flags any read word whose ninth bit does not give even parity. Both ports share one clock.

Top module: `dual_port_store`

## Requirements
- R1: After reset: empty=1, full=0, level=0, overflow=0, underflow=0, par_err=0.
- R2: In addressed mode (cfg_fifo=0), wr_en stores wr_data at wr_addr on the clock edge. With cfg_rd_reg=0, rd_data shows the word at rd_addr combinationally, as the array holds it before that cycle's edge.
- R3: With cfg_rd_reg=1, a read issued in one cycle presents its word on rd_data after the next clock edge. rd_data keeps its value while no read is accepted. A read of an address written in the same cycle returns the old word.
- R4: With cfg_wr_reg=1, a write first passes through an input register. It is stored at the second clock edge after it is issued, so a read in the following cycle still sees the old word.
- R5: When cfg_par[0]=1, the stored bit 8 is the XOR of wr_data[7:0], so that all nine bits hold an even number of ones. The caller's bit 8 is discarded.
- R6: When cfg_par[1]=1 and an accepted read returns a word whose bit 8 differs from the XOR of bits 7:0, par_err is high for exactly the one cycle in which that word is first presented. That is the read cycle itself with cfg_rd_reg=0, and the cycle after the edge with cfg_rd_reg=1.
- R7: In queue mode (cfg_fifo=1), words come out in the order they were written, and level equals the number of stored words. The write and read pointers are 9 bits wide, and the top bit is a wrap flag.
- R8: full is high when the pointers differ only in the wrap flag, so level=256. A write while full is dropped and leaves the contents unchanged. It also sets overflow, which stays set until reset.
- R9: empty is high when the pointers are equal. A read while empty leaves the read pointer unchanged, and with cfg_rd_reg=1 rd_data keeps the last word. It also sets underflow, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo | input | 1 | 1 = queue mode, 0 = addressed mode |
| cfg_wr_reg | input | 1 | 1 = write inputs pass through an input register |
| cfg_rd_reg | input | 1 | 1 = registered read output |
| cfg_par | input | 2 | bit 0 generates parity on write, bit 1 checks parity on read |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write address (addressed mode) |
| wr_data | input | 9 | Write word |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read address (addressed mode) |
| rd_data | output | 9 | Read word |
| par_err | output | 1 | Parity mismatch on the presented read word |
| full | output | 1 | Queue holds 256 words |
| empty | output | 1 | Queue holds no words |
| level | output | 9 | Number of stored words in queue mode |
| overflow | output | 1 | Sticky: a write was attempted while full |
| underflow | output | 1 | Sticky: a read was attempted while empty |

## Verification
A combinational read is due in the same cycle it is issued. The bench drives inputs just after the rising edge and compares at the falling edge of that same cycle. A registered read, and its parity flag, are due one edge later, so the driver stamps each expected item with the cycle in which it is due. The monitor pops and compares only when the cycle counter reaches that stamp. A registered write moves the moment a word becomes readable back by one further cycle. Flags and level are sampled at the falling edge that follows an idle cycle, after every edge that could have changed them.

// File: rtl/dps_pkg.sv
package dps_pkg;
  // bit positions inside the parity configuration field
  localparam int PAR_GEN = 0;
  localparam int PAR_CHK = 1;

  // even-parity bit of a zero-extended word
  function automatic logic even_bit(input logic [31:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/dps_wr_stage.sv
module dps_wr_stage #(
  parameter int AW = 8,
  parameter int WW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_mode,
  input  logic          in_en,
  input  logic [AW-1:0] in_addr,
  input  logic [WW-1:0] in_data,
  output logic          out_en,
  output logic [AW-1:0] out_addr,
  output logic [WW-1:0] out_data
);
  logic          q_en;
  logic [AW-1:0] q_addr;
  logic [WW-1:0] q_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_en   <= 1'b0;
      q_addr <= '0;
      q_data <= '0;
    end else begin
      q_en   <= in_en;
      q_addr <= in_addr;
      q_data <= in_data;
    end
  end

  assign out_en   = reg_mode ? q_en   : in_en;
  assign out_addr = reg_mode ? q_addr : in_addr;
  assign out_data = reg_mode ? q_data : in_data;
endmodule

// File: rtl/dps_fifo_ctl.sv
module dps_fifo_ctl #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          push_req,
  input  logic          pop_req,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          full,
  output logic          empty,
  output logic [AW:0]   level,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          overflow,
  output logic          underflow
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] WRAP = {1'b1, {AW{1'b0}}};
  localparam logic [PW-1:0] ONE  = {{AW{1'b0}}, 1'b1};

  function automatic logic [PW-1:0] ptr_gap(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w - r;
  endfunction

  function automatic logic ptrs_full(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return (w ^ r) == WRAP;
  endfunction

  function automatic logic ptrs_empty(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w == r;
  endfunction

  logic [PW-1:0] wptr, rptr;

  assign full    = ptrs_full(wptr, rptr);
  assign empty   = ptrs_empty(wptr, rptr);
  assign level   = ptr_gap(wptr, rptr);
  assign push_ok = fifo_mode && push_req && !full;
  assign pop_ok  = fifo_mode && pop_req && !empty;
  assign waddr   = wptr[AW-1:0];
  assign raddr   = rptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (push_ok) wptr <= wptr + ONE;
      if (pop_ok)  rptr <= rptr + ONE;
      if (fifo_mode && push_req && full)  overflow  <= 1'b1;
      if (fifo_mode && pop_req && empty)  underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/dps_array.sv
module dps_array #(
  parameter int AW = 8,
  parameter int WW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dps_rd_stage.sv
module dps_rd_stage #(
  parameter int DW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_mode,
  input  logic        chk_en,
  input  logic        fire,
  input  logic [DW:0] arr_data,
  output logic [DW:0] rd_data,
  output logic        par_err
);
  import dps_pkg::*;

  logic        word_bad;
  logic [DW:0] q_data;
  logic        q_err;

  assign word_bad = arr_data[DW] != even_bit(32'(arr_data[DW-1:0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_data <= '0;
      q_err  <= 1'b0;
    end else begin
      if (fire) q_data <= arr_data;
      q_err <= fire && chk_en && word_bad;
    end
  end

  assign rd_data = reg_mode ? q_data : arr_data;
  assign par_err = reg_mode ? q_err : (fire && chk_en && word_bad);
endmodule

// File: rtl/dual_port_store.sv
module dual_port_store #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_fifo,
  input  logic          cfg_wr_reg,
  input  logic          cfg_rd_reg,
  input  logic [1:0]    cfg_par,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW:0]   wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW:0]   rd_data,
  output logic          par_err,
  output logic          full,
  output logic          empty,
  output logic [AW:0]   level,
  output logic          overflow,
  output logic          underflow
);
  import dps_pkg::*;

  localparam int WW = DW + 1;

  // named internal events, visible to the bound checker
  logic          wq_en;
  logic [AW-1:0] wq_addr;
  logic [WW-1:0] wq_data;
  logic          push_ok, pop_ok, rd_fire;
  logic [AW-1:0] q_waddr, q_raddr;
  logic          arr_we;
  logic [AW-1:0] arr_waddr, arr_raddr;
  logic [WW-1:0] arr_wdata, arr_rdata, gen_word;

  dps_wr_stage #(.AW(AW), .WW(WW)) u_wr (
    .clk(clk), .rst_n(rst_n), .reg_mode(cfg_wr_reg),
    .in_en(wr_en), .in_addr(wr_addr), .in_data(wr_data),
    .out_en(wq_en), .out_addr(wq_addr), .out_data(wq_data)
  );

  dps_fifo_ctl #(.AW(AW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .fifo_mode(cfg_fifo),
    .push_req(wq_en), .pop_req(rd_en),
    .waddr(q_waddr), .raddr(q_raddr),
    .full(full), .empty(empty), .level(level),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .overflow(overflow), .underflow(underflow)
  );

  assign gen_word  = {even_bit(32'(wq_data[DW-1:0])), wq_data[DW-1:0]};
  assign arr_we    = cfg_fifo ? push_ok : wq_en;
  assign arr_waddr = cfg_fifo ? q_waddr : wq_addr;
  assign arr_wdata = cfg_par[PAR_GEN] ? gen_word : wq_data;
  assign arr_raddr = cfg_fifo ? q_raddr : rd_addr;
  assign rd_fire   = cfg_fifo ? pop_ok  : rd_en;

  dps_array #(.AW(AW), .WW(WW)) u_mem (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );

  dps_rd_stage #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .reg_mode(cfg_rd_reg),
    .chk_en(cfg_par[PAR_CHK]), .fire(rd_fire),
    .arr_data(arr_rdata), .rd_data(rd_data), .par_err(par_err)
  );
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int AW = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        full,
  input logic        empty,
  input logic [AW:0] level,
  input logic        push_ok,
  input logic        pop_ok,
  input logic        overflow,
  input logic        underflow,
  input logic        par_err,
  input logic        chk_en
);
  localparam logic [AW:0] CAP = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] ONE = {{AW{1'b0}}, 1'b1};

  // R1: never full and empty together
  a_r1_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R7: level bounded by capacity
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CAP);

  // R7: a lone accepted push raises the level by one
  a_r7_level_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> level == $past(level) + ONE);

  // R8: no push accepted while full
  a_r8_full_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_ok);

  // R8: overflow stays set
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9: no pop accepted while empty
  a_r9_empty_blocks_pop: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop_ok);

  // R9: underflow stays set
  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R6: a parity error only appears with checking enabled now or one cycle ago
  a_r6_err_needs_check: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> (chk_en || $past(chk_en)));
endmodule

bind dual_port_store dps_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .full(full), .empty(empty), .level(level),
  .push_ok(push_ok), .pop_ok(pop_ok), .overflow(overflow),
  .underflow(underflow), .par_err(par_err), .chk_en(cfg_par[1])
);

// File: tb/dual_port_store_test.sv
`timescale 1ns/1ps
module dual_port_store_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_fifo = 1'b0, cfg_wr_reg = 1'b0, cfg_rd_reg = 1'b0;
  logic [1:0] cfg_par = 2'b00;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       par_err, full, empty, overflow, underflow;
  logic [8:0] level;

  always #2 clk = ~clk;  // 250 MHz

  dual_port_store uut (
    .clk(clk), .rst_n(rst_n), .cfg_fifo(cfg_fifo), .cfg_wr_reg(cfg_wr_reg),
    .cfg_rd_reg(cfg_rd_reg), .cfg_par(cfg_par), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .par_err(par_err), .full(full), .empty(empty), .level(level),
    .overflow(overflow), .underflow(underflow)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [8:0] d;
    logic       pe;
    int         due;
    string      req;
  } exp_t;
  exp_t sb[$];

  // reference state
  logic [8:0] mm [256];
  logic [8:0] fq [$];
  logic [8:0] last_s = '0;
  logic       of_m = 1'b0, uf_m = 1'b0;
  logic       pend = 1'b0;
  logic [7:0] pa = '0;
  logic [8:0] pd = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] stored(input logic [8:0] d);
    return cfg_par[0] ? {^d[7:0], d[7:0]} : d;
  endfunction

  function automatic logic odd_word(input logic [8:0] w);
    return w[8] != (^w[7:0]);
  endfunction

  // monitor: compare results as they fall due
  exp_t got;
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      got = sb.pop_front();
      if (got.due < cyc) check({got.req, " missed slot"}, 32'(got.due), 32'(cyc));
      else begin
        check({got.req, " rd_data"}, 32'(rd_data), 32'(got.d));
        check({got.req, " par_err"}, 32'(par_err), 32'(got.pe));
      end
    end
  end

  // driver: one clock cycle of stimulus, expected results pushed to the scoreboard
  task automatic step(input logic we, input logic [7:0] wa, input logic [8:0] wd,
                      input logic re, input logic [7:0] ra);
    logic fire;
    logic [8:0] rv;
    logic pe;
    int sz0;
    exp_t it;
    @(posedge clk); #1;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    fire = 1'b0; rv = last_s;
    if (cfg_fifo) begin
      sz0 = fq.size();
      if (re && sz0 > 0) begin fire = 1'b1; rv = fq[0]; end
      if (re && sz0 == 0) uf_m = 1'b1;
      if (we && sz0 == 256) of_m = 1'b1;
      if (fire) void'(fq.pop_front());
      if (we && sz0 < 256) fq.push_back(stored(wd));
    end else begin
      if (re) begin fire = 1'b1; rv = mm[ra]; end
      if (pend) mm[pa] = pd;
      pend = 1'b0;
      if (we) begin
        if (cfg_wr_reg) begin pend = 1'b1; pa = wa; pd = stored(wd); end
        else mm[wa] = stored(wd);
      end
    end
    pe = fire && cfg_par[1] && odd_word(rv);
    if (fire) last_s = rv;
    if (cfg_rd_reg) begin
      it.d = last_s; it.pe = pe; it.due = cyc + 1; it.req = cur_req;
      sb.push_back(it);
    end else if (fire) begin
      it.d = rv; it.pe = pe; it.due = cyc; it.req = cur_req;
      sb.push_back(it);
    end
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 9'h000, 1'b0, 8'h00);
  endtask

  task automatic set_cfg(input logic f, input logic wreg, input logic rreg, input logic [1:0] p);
    @(negedge clk); @(negedge clk); #0.5;
    cfg_fifo = f; cfg_wr_reg = wreg; cfg_rd_reg = rreg; cfg_par = p;
  endtask

  task automatic check_flags(input string req);
    idle();
    @(negedge clk);
    check({req, " full"},      32'(full),      32'(fq.size() == 256));
    check({req, " empty"},     32'(empty),     32'(fq.size() == 0));
    check({req, " level"},     32'(level),     32'(fq.size()));
    check({req, " overflow"},  32'(overflow),  32'(of_m));
    check({req, " underflow"}, 32'(underflow), 32'(uf_m));
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", 32'(empty), 32'd1);
    check("R1 full", 32'(full), 32'd0);
    check("R1 level", 32'(level), 32'd0);
    check("R1 overflow", 32'(overflow), 32'd0);
    check("R1 underflow", 32'(underflow), 32'd0);
    check("R1 par_err", 32'(par_err), 32'd0);

    // R2 addressed mode, combinational read
    cur_req = "R2";
    for (int i = 0; i < 8; i++) step(1'b1, 8'(i * 3), 9'(9'h055 + i * 37), 1'b0, 8'h00);
    step(1'b1, 8'hFF, 9'h1C3, 1'b0, 8'h00);
    for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 9'h000, 1'b1, 8'(i * 3));
    step(1'b1, 8'h03, 9'h111, 1'b1, 8'h03);  // same-cycle write, old word shown
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'hFF);
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h03);
    idle();

    // R3 registered read, hold, read-during-write
    set_cfg(1'b0, 1'b0, 1'b1, 2'b00);
    cur_req = "R3";
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h06);
    step(1'b1, 8'h06, 9'h0EE, 1'b1, 8'h06);
    idle();
    idle();
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h06);
    idle();

    // R4 registered write port
    set_cfg(1'b0, 1'b1, 1'b0, 2'b00);
    cur_req = "R4";
    step(1'b1, 8'h0A, 9'h0AB, 1'b0, 8'h00);
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h0A);
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h0A);
    idle();
    idle();

    // R5 parity generation
    set_cfg(1'b0, 1'b0, 1'b0, 2'b01);
    cur_req = "R5";
    step(1'b1, 8'h14, 9'h1A5, 1'b0, 8'h00);
    step(1'b1, 8'h15, 9'h007, 1'b0, 8'h00);
    idle();
    set_cfg(1'b0, 1'b0, 1'b0, 2'b00);
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h14);  // expect 0A5
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h15);  // expect 107
    idle();

    // R6 parity checking, both read timings
    cur_req = "R6";
    step(1'b1, 8'h1E, 9'h100, 1'b0, 8'h00);
    step(1'b1, 8'h1F, 9'h001, 1'b0, 8'h00);
    step(1'b1, 8'h20, 9'h101, 1'b0, 8'h00);
    idle();
    set_cfg(1'b0, 1'b0, 1'b0, 2'b10);
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h1E);
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h20);
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h1F);
    idle();
    set_cfg(1'b0, 1'b0, 1'b1, 2'b10);
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h1E);
    idle();                                   // error must last one cycle only
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h20);
    idle();

    // R7 queue order and level
    set_cfg(1'b1, 1'b0, 1'b0, 2'b00);
    cur_req = "R7";
    step(1'b1, 8'h00, 9'h011, 1'b0, 8'h00);
    step(1'b1, 8'h00, 9'h122, 1'b0, 8'h00);
    step(1'b1, 8'h00, 9'h033, 1'b0, 8'h00);
    check_flags("R7");
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h00);
    step(1'b1, 8'h00, 9'h044, 1'b1, 8'h00);
    check_flags("R7");
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h00);
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h00);
    check_flags("R7");

    // R8 fill to capacity, drop extra write
    cur_req = "R8";
    for (int i = 0; i < 256; i++) step(1'b1, 8'h00, 9'(i * 5 + 1), 1'b0, 8'h00);
    check_flags("R8");
    step(1'b1, 8'h00, 9'h1AA, 1'b0, 8'h00);
    check_flags("R8");
    for (int i = 0; i < 256; i++) step(1'b0, 8'h00, 9'h000, 1'b1, 8'h00);
    check_flags("R8");

    // R9 read while empty, registered read keeps last word
    set_cfg(1'b1, 1'b0, 1'b1, 2'b00);
    cur_req = "R9";
    step(1'b1, 8'h00, 9'h0C7, 1'b0, 8'h00);
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h00);
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h00);  // empty: no move
    idle();
    check_flags("R9");
    step(1'b1, 8'h00, 9'h13C, 1'b0, 8'h00);
    step(1'b0, 8'h00, 9'h000, 1'b1, 8'h00);
    check_flags("R9");

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule